// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns a floating-point operand that has already been unpacked into a saturating two's-complement signed integer of `INT_W` bits, where `INT_W` is 32 or 64. The operand arrives as a class code, a sign, a signed unbiased exponent, a mantissa and a sticky bit. The mantissa is normalised with its most significant bit worth 2^exp, so an operand of class number has the value mant * 2^(exp - (MANT_W-1)). A two-bit rounding mode and a force-toward-zero input pick the rounding rule. The result comes back on a 64-bit word, with five status bits beside it.

Values that cannot be represented saturate to a limit chosen by the sign. NaNs of either kind count as negative. A conversion that reports invalid never reports inexact or rounded as well. The block does not decode packed formats.

A small state machine runs the conversion over four states:
- `S_IDLE` waits. It moves to `S_ALIGN` when `in_valid` is high, and captures the operand and the effective rounding mode as it does.
- `S_ALIGN` shifts the mantissa so that the integer part is aligned, and registers the guard and remaining bits. It always moves to `S_ROUND`.
- `S_ROUND` rounds, tests the range, saturates or negates, and registers the result and status. It always moves to `S_EMIT`.
- `S_EMIT` raises `res_valid` for one cycle and returns to `S_IDLE`.

Top module: `fcvt_int_core`

## Requirements
- R1: A conversion is accepted only when `in_valid` is high in `S_IDLE`, and its result appears with `res_valid` high for exactly one cycle, three clock edges after the accepting edge. `in_valid` in any other state is ignored and produces no result.
- R2: After reset `res_valid`, `res_data` and all five status outputs are 0.
- R3: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN. A zero, or any unlisted code, returns 0 with every status bit clear, whatever the sign.
- R4: `rnd_mode` encodes 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. When `force_rz` is high, toward-zero rounding is used whatever `rnd_mode` says.
- R5: In nearest mode the magnitude is incremented when the guard bit is set and either any lower discarded bit is set or the least significant integer bit is 1. An exact tie therefore goes to the even integer.
- R6: The first bit shifted below the integer point is the guard bit. All lower bits, together with `op_sticky`, form the remainder. Negative exponents give an integer part of 0 under the same rules.
- R7: After rounding, a magnitude of at least 2^(INT_W-1) + sign is out of range. A magnitude of exactly 2^(INT_W-1) is legal only for a negative value.
- R8: An infinity, a number with exponent >= INT_W, or an out-of-range result gives 2^(INT_W-1)-1 when positive and -2^(INT_W-1) when negative. It sets `st_invalid_conv` and clears `st_inexact`, `st_frac_inexact` and `st_frac_rounded`.
- R9: A signalling NaN sets `st_invalid_snan`. Both NaN kinds then saturate as a negative value, returning -2^(INT_W-1) with `st_invalid_conv` set.
- R10: An in-range result is the magnitude, negated in two's complement when the sign is set, and zero-extended to 64 bits. `st_inexact` and `st_frac_inexact` are set when any discarded bit is nonzero, and `st_frac_rounded` is set when the magnitude was incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start a conversion (taken in `S_IDLE` only) |
| op_class | input | 3 | Operand class code |
| op_sign | input | 1 | Operand sign, 1 = negative |
| op_exp | input | EXP_W | Signed unbiased exponent |
| op_mant | input | MANT_W | Normalised mantissa, MSB worth 2^exp |
| op_sticky | input | 1 | OR of mantissa bits lost before this block |
| rnd_mode | input | 2 | Rounding mode selector |
| force_rz | input | 1 | Override the mode with toward-zero |
| res_valid | output | 1 | Result valid, one-cycle pulse |
| res_data | output | 64 | Integer result, zero-extended |
| st_inexact | output | 1 | Result differs from the operand |
| st_frac_inexact | output | 1 | Fraction bits were discarded |
| st_frac_rounded | output | 1 | Magnitude was incremented |
| st_invalid_conv | output | 1 | Saturated or invalid conversion |
| st_invalid_snan | output | 1 | Operand was a signalling NaN |

## Verification
The in-RTL assertions check the following on every cycle:
- the fixed three-edge latency and the single-cycle result pulse;
- that invalid never appears together with inexact or rounded;
- that rounded implies inexact;
- that a saturated result is one of the two limit patterns;
- that a signalling NaN always comes with invalid and a negative limit;
- that the bits above `INT_W` stay zero.

The actual numeric values can only be shown by the bench's scenarios, which compare each result against a model of the requirements. These scenarios cover:
- nearest-even ties on both even and odd integers;
- each directed rounding direction for both signs;
- the override by `force_rz`;
- negative exponents where only guard or remainder survive;
- the asymmetric 2^(INT_W-1) boundary;
- a request dropped while the block is busy.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ALIGN = 2'd1,
        S_ROUND = 2'd2,
        S_EMIT  = 2'd3
    } fsm_state_e;

endpackage

// File: rtl/fcvt_align.sv
// Aligns the mantissa so the integer part lands in the low INT_W bits and
// extracts the guard bit and the OR of everything below it.
module fcvt_align #(
    parameter int INT_W  = 32,
    parameter int MANT_W = 64,
    parameter int EXP_W  = 12
) (
    input  logic signed [EXP_W-1:0]  exp_i,
    input  logic        [MANT_W-1:0] mant_i,
    input  logic                     sticky_i,
    output logic                     too_big_o,
    output logic        [INT_W-1:0]  int_o,
    output logic                     guard_o,
    output logic                     rest_o
);
    // binary point of the extended word sits at bit 2*MANT_W
    localparam int EXT_W = 2 * MANT_W + INT_W;
    localparam int T_MAX = MANT_W + INT_W;
    localparam int T_W   = $clog2(T_MAX + 1);

    logic [T_W-1:0]   shift_amt;
    logic [EXT_W-1:0] ext;
    int               t_raw;

    always_comb begin
        too_big_o = (int'(exp_i) >= INT_W);
        t_raw     = INT_W - 1 - int'(exp_i);
        if (t_raw < 0)
            shift_amt = '0;
        else if (t_raw > T_MAX)
            shift_amt = T_W'(T_MAX);    // deeper shifts only move bits into rest
        else
            shift_amt = T_W'(t_raw);
        ext     = {mant_i, {(MANT_W + INT_W){1'b0}}} >> shift_amt;
        int_o   = ext[EXT_W-1 -: INT_W];
        guard_o = ext[2*MANT_W-1];
        rest_o  = (|ext[2*MANT_W-2:0]) | sticky_i;
    end

endmodule

// File: rtl/fcvt_round.sv
// Rounds the aligned magnitude, checks the signed range and builds the
// result and status for every operand class.
module fcvt_round
    import fcvt_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  op_class_e              cls_i,
    input  logic                   sign_i,
    input  rnd_mode_e              mode_i,
    input  logic                   too_big_i,
    input  logic      [INT_W-1:0]  int_i,
    input  logic                   guard_i,
    input  logic                   rest_i,
    output logic      [INT_W-1:0]  res_o,
    output logic                   inexact_o,
    output logic                   rounded_o,
    output logic                   inv_conv_o,
    output logic                   inv_snan_o
);
    logic             lost;
    logic             bump;
    logic [INT_W:0]   mag;
    logic [INT_W:0]   limit;
    logic             over;
    logic [INT_W-1:0] sat_pos;
    logic [INT_W-1:0] sat_neg;

    always_comb begin
        lost = guard_i | rest_i;
        case (mode_i)
            RM_NEAREST: bump = guard_i & (rest_i | int_i[0]);
            RM_ZERO:    bump = 1'b0;
            RM_UP:      bump = lost & ~sign_i;
            RM_DOWN:    bump = lost & sign_i;
            default:    bump = 1'b0;
        endcase
        mag     = {1'b0, int_i} + {{INT_W{1'b0}}, bump};
        limit   = {2'b01, {(INT_W-1){1'b0}}} + {{INT_W{1'b0}}, sign_i};
        over    = too_big_i || (mag >= limit);
        sat_pos = {1'b0, {(INT_W-1){1'b1}}};
        sat_neg = {1'b1, {(INT_W-1){1'b0}}};

        res_o      = '0;
        inexact_o  = 1'b0;
        rounded_o  = 1'b0;
        inv_conv_o = 1'b0;
        inv_snan_o = 1'b0;
        case (cls_i)
            CLS_NUM: begin
                if (over) begin
                    res_o      = sign_i ? sat_neg : sat_pos;
                    inv_conv_o = 1'b1;
                end else begin
                    res_o     = sign_i ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];
                    inexact_o = lost;
                    rounded_o = bump;
                end
            end
            CLS_INF: begin
                res_o      = sign_i ? sat_neg : sat_pos;
                inv_conv_o = 1'b1;
            end
            CLS_QNAN: begin
                res_o      = sat_neg;
                inv_conv_o = 1'b1;
            end
            CLS_SNAN: begin
                res_o      = sat_neg;
                inv_conv_o = 1'b1;
                inv_snan_o = 1'b1;
            end
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/fcvt_int_core.sv
module fcvt_int_core
    import fcvt_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int MANT_W = 64,
    parameter int EXP_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic        [2:0]        op_class,
    input  logic                     op_sign,
    input  logic signed [EXP_W-1:0]  op_exp,
    input  logic        [MANT_W-1:0] op_mant,
    input  logic                     op_sticky,
    input  logic        [1:0]        rnd_mode,
    input  logic                     force_rz,
    output logic                     res_valid,
    output logic        [63:0]       res_data,
    output logic                     st_inexact,
    output logic                     st_frac_inexact,
    output logic                     st_frac_rounded,
    output logic                     st_invalid_conv,
    output logic                     st_invalid_snan
);
    if (!(INT_W == 32 || INT_W == 64)) begin : g_bad_width
        $error("fcvt_int_core: INT_W must be 32 or 64");
    end

    fsm_state_e state, state_nxt;

    // operand capture (S_IDLE)
    op_class_e               a_cls;
    logic                    a_sign;
    logic signed [EXP_W-1:0] a_exp;
    logic [MANT_W-1:0]       a_mant;
    logic                    a_sticky;
    rnd_mode_e               a_mode;

    // aligned operand (S_ALIGN)
    op_class_e               b_cls;
    logic                    b_sign;
    rnd_mode_e               b_mode;
    logic                    b_too_big;
    logic [INT_W-1:0]        b_int;
    logic                    b_guard;
    logic                    b_rest;

    logic                    al_too_big;
    logic [INT_W-1:0]        al_int;
    logic                    al_guard;
    logic                    al_rest;

    logic [INT_W-1:0]        rd_res;
    logic                    rd_inexact;
    logic                    rd_rounded;
    logic                    rd_inv_conv;
    logic                    rd_inv_snan;
    logic [63:0]             rd_wide;

    fcvt_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
        .exp_i     (a_exp),
        .mant_i    (a_mant),
        .sticky_i  (a_sticky),
        .too_big_o (al_too_big),
        .int_o     (al_int),
        .guard_o   (al_guard),
        .rest_o    (al_rest)
    );

    fcvt_round #(.INT_W(INT_W)) u_round (
        .cls_i      (b_cls),
        .sign_i     (b_sign),
        .mode_i     (b_mode),
        .too_big_i  (b_too_big),
        .int_i      (b_int),
        .guard_i    (b_guard),
        .rest_i     (b_rest),
        .res_o      (rd_res),
        .inexact_o  (rd_inexact),
        .rounded_o  (rd_rounded),
        .inv_conv_o (rd_inv_conv),
        .inv_snan_o (rd_inv_snan)
    );

    always_comb begin
        rd_wide            = '0;
        rd_wide[INT_W-1:0] = rd_res;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (in_valid) state_nxt = S_ALIGN;
            S_ALIGN: state_nxt = S_ROUND;
            S_ROUND: state_nxt = S_EMIT;
            S_EMIT:  state_nxt = S_IDLE;
        endcase
    end

    assign res_valid = (state == S_EMIT);

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cls           <= CLS_ZERO;
            a_sign          <= 1'b0;
            a_exp           <= '0;
            a_mant          <= '0;
            a_sticky        <= 1'b0;
            a_mode          <= RM_NEAREST;
            b_cls           <= CLS_ZERO;
            b_sign          <= 1'b0;
            b_mode          <= RM_NEAREST;
            b_too_big       <= 1'b0;
            b_int           <= '0;
            b_guard         <= 1'b0;
            b_rest          <= 1'b0;
            res_data        <= '0;
            st_inexact      <= 1'b0;
            st_frac_inexact <= 1'b0;
            st_frac_rounded <= 1'b0;
            st_invalid_conv <= 1'b0;
            st_invalid_snan <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (in_valid) begin
                    a_cls    <= op_class_e'(op_class);
                    a_sign   <= op_sign;
                    a_exp    <= op_exp;
                    a_mant   <= op_mant;
                    a_sticky <= op_sticky;
                    a_mode   <= force_rz ? RM_ZERO : rnd_mode_e'(rnd_mode);
                end
                S_ALIGN: begin
                    b_cls     <= a_cls;
                    b_sign    <= a_sign;
                    b_mode    <= a_mode;
                    b_too_big <= al_too_big;
                    b_int     <= al_int;
                    b_guard   <= al_guard;
                    b_rest    <= al_rest;
                end
                S_ROUND: begin
                    res_data        <= rd_wide;
                    st_inexact      <= rd_inexact;
                    st_frac_inexact <= rd_inexact;
                    st_frac_rounded <= rd_rounded;
                    st_invalid_conv <= rd_inv_conv;
                    st_invalid_snan <= rd_inv_snan;
                end
                S_EMIT: ;
            endcase
        end
    end

    // R1: accepted request yields a result three edges later
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_valid) |-> ##3 res_valid);

    // R1: result strobe lasts one cycle
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8: invalid hides inexact and rounded
    p_invalid_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && st_invalid_conv) |-> (!st_inexact && !st_frac_inexact && !st_frac_rounded));

    // R8: saturated values are one of the two limits
    p_sat_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && st_invalid_conv) |->
            ((res_data[INT_W-2:0] == '0 && res_data[INT_W-1]) ||
             (&res_data[INT_W-2:0] && !res_data[INT_W-1])));

    // R9: signalling NaN is invalid and negative-saturated
    p_snan_negative_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && st_invalid_snan) |-> (st_invalid_conv && res_data[INT_W-1]));

    // R10: rounding up implies inexact
    p_rounded_inexact_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && st_frac_rounded) |-> (st_inexact && st_frac_inexact));

    // R10: bits above the integer width stay zero
    p_zero_extend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_data >> INT_W) == 64'd0));

endmodule

// File: tb/test_fcvt_int_core.sv
module test_fcvt_int_core;

    localparam int N = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [2:0]         op_class = '0;
    logic               op_sign = 1'b0;
    logic signed [11:0] op_exp = '0;
    logic [63:0]        op_mant = '0;
    logic               op_sticky = 1'b0;
    logic [1:0]         rnd_mode = '0;
    logic               force_rz = 1'b0;
    logic               res_valid;
    logic [63:0]        res_data;
    logic               st_inexact, st_frac_inexact, st_frac_rounded;
    logic               st_invalid_conv, st_invalid_snan;

    int checks = 0;
    int fails  = 0;

    logic [63:0] q_data[$];
    logic [4:0]  q_st[$];
    string       q_tag[$];

    always #4 clk = ~clk;   // 125 MHz

    fcvt_int_core #(.INT_W(N), .MANT_W(64), .EXP_W(12)) i_fcvt_int_core (
        .clk, .rst_n, .in_valid, .op_class, .op_sign, .op_exp, .op_mant,
        .op_sticky, .rnd_mode, .force_rz, .res_valid, .res_data,
        .st_inexact, .st_frac_inexact, .st_frac_rounded,
        .st_invalid_conv, .st_invalid_snan
    );

    // status vector: {snan, invalid, rounded, frac_inexact, inexact}
    function automatic void model(input int cls, input bit sgn, input int e,
                                  input logic [63:0] m, input bit stk,
                                  input int mode, input bit frz,
                                  output logic [63:0] d, output logic [4:0] st);
        longint unsigned ip, mag, lim;
        bit g, r, inc;
        int md, sh;
        md = frz ? 1 : mode;
        d = 64'd0; st = 5'b0;
        if (cls == 2 || cls == 3 || cls == 4 || (cls == 1 && e >= N)) begin
            bit neg;
            neg = (cls == 3 || cls == 4) ? 1'b1 : sgn;
            d  = neg ? 64'h8000_0000 : 64'h7FFF_FFFF;
            st = (cls == 4) ? 5'b11000 : 5'b01000;
        end else if (cls == 1) begin
            if (e >= 0) begin
                sh = 63 - e;
                ip = m >> sh;
                g  = m[sh-1];
                r  = ((m & ((64'd1 << (sh - 1)) - 64'd1)) != 0) || stk;
            end else if (e == -1) begin
                ip = 0; g = m[63]; r = (m[62:0] != 0) || stk;
            end else begin
                ip = 0; g = 1'b0; r = (m != 0) || stk;
            end
            case (md)
                0: inc = g && (r || ip[0]);
                1: inc = 1'b0;
                2: inc = (g || r) && !sgn;
                default: inc = (g || r) && sgn;
            endcase
            mag = ip + longint'(inc);
            lim = 64'h8000_0000 + longint'(sgn);
            if (mag >= lim) begin
                d  = sgn ? 64'h8000_0000 : 64'h7FFF_FFFF;
                st = 5'b01000;
            end else begin
                d  = {32'd0, sgn ? 32'(-mag) : 32'(mag)};
                st = {2'b00, inc, (g || r), (g || r)};
            end
        end
    endfunction

    task automatic drive(input int cls, input bit sgn, input int e,
                         input logic [63:0] m, input bit stk, input int mode,
                         input bit frz);
        op_class  = 3'(cls);
        op_sign   = sgn;
        op_exp    = 12'(e);
        op_mant   = m;
        op_sticky = stk;
        rnd_mode  = 2'(mode);
        force_rz  = frz;
        in_valid  = 1'b1;
    endtask

    task automatic apply(input int cls, input bit sgn, input int e,
                         input logic [63:0] m, input bit stk, input int mode,
                         input bit frz, input string tag);
        logic [63:0] d;
        logic [4:0]  st;
        model(cls, sgn, e, m, stk, mode, frz, d, st);
        q_data.push_back(d); q_st.push_back(st); q_tag.push_back(tag);
        @(negedge clk); drive(cls, sgn, e, m, stk, mode, frz);
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && res_valid) begin
                checks++;
                if (q_data.size() == 0) begin
                    fails++;
                    $display("FAIL R1 unexpected result: data=%h status=%b expected no result",
                             res_data, {st_invalid_snan, st_invalid_conv, st_frac_rounded,
                                        st_frac_inexact, st_inexact});
                end else begin
                    logic [63:0] ed;
                    logic [4:0]  es, got;
                    string       tg;
                    ed = q_data.pop_front(); es = q_st.pop_front(); tg = q_tag.pop_front();
                    got = {st_invalid_snan, st_invalid_conv, st_frac_rounded,
                           st_frac_inexact, st_inexact};
                    if (res_data !== ed || got !== es) begin
                        fails++;
                        $display("FAIL %s: data=%h status=%b expected data=%h status=%b",
                                 tg, res_data, got, ed, es);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        checks++;
        if (res_valid !== 1'b0 || res_data !== 64'd0 ||
            {st_invalid_snan, st_invalid_conv, st_frac_rounded, st_frac_inexact, st_inexact} !== 5'b0) begin
            fails++;
            $display("FAIL R2: valid=%b data=%h expected valid=0 data=0", res_valid, res_data);
        end

        // R3: zero and unlisted class
        apply(0, 1, 5, ONE, 1, 0, 0, "R3 zero");
        apply(6, 0, 3, ONE, 1, 2, 0, "R3 unlisted class");
        // R10: plain values
        apply(1, 0, 0, ONE, 0, 0, 0, "R10 +1");
        apply(1, 1, 0, ONE, 0, 0, 0, "R10 -1");
        apply(1, 1, 20, 64'hF123_4567_89AB_CDEF, 0, 1, 0, "R10 negative large");
        // R5: ties
        apply(1, 0, 1, 64'hA000_0000_0000_0000, 0, 0, 0, "R5 2.5 to even");
        apply(1, 0, 1, 64'hE000_0000_0000_0000, 0, 0, 0, "R5 3.5 to even");
        apply(1, 1, 1, 64'hA000_0000_0000_0001, 0, 0, 0, "R5 -2.5+ above tie");
        // R4: directed modes and override
        apply(1, 0, 1, 64'hA000_0000_0000_0000, 0, 1, 0, "R4 toward zero");
        apply(1, 0, 1, 64'hA000_0000_0000_0000, 0, 2, 0, "R4 toward +inf");
        apply(1, 0, 1, 64'hA000_0000_0000_0000, 0, 3, 0, "R4 toward -inf pos");
        apply(1, 1, 1, 64'hA000_0000_0000_0000, 0, 3, 0, "R4 toward -inf neg");
        apply(1, 1, 1, 64'hA000_0000_0000_0000, 0, 2, 0, "R4 toward +inf neg");
        apply(1, 0, 1, 64'hA000_0000_0000_0000, 0, 2, 1, "R4 force_rz override");
        // R6: negative exponents and sticky
        apply(1, 0, -2, ONE, 0, 0, 0, "R6 0.25 nearest");
        apply(1, 0, -2, ONE, 0, 2, 0, "R6 0.25 up");
        apply(1, 0, -1, ONE, 0, 0, 0, "R6 0.5 tie");
        apply(1, 1, -1, 64'hC000_0000_0000_0000, 0, 0, 0, "R6 -0.75 nearest");
        apply(1, 0, -80, ONE, 0, 3, 0, "R6 tiny toward -inf");
        apply(1, 1, -80, ONE, 0, 3, 0, "R6 tiny negative toward -inf");
        apply(1, 0, 0, ONE, 1, 2, 0, "R6 sticky only");
        // R7: range boundary
        apply(1, 0, 31, ONE, 0, 0, 0, "R7 +2^31 overflow");
        apply(1, 1, 31, ONE, 0, 0, 0, "R7 -2^31 legal");
        apply(1, 0, 30, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R7 rounds up to +2^31");
        apply(1, 1, 30, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R7 rounds up to -2^31");
        apply(1, 0, 30, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, "R7 truncates to max");
        // R8: saturation
        apply(1, 0, 32, ONE, 0, 0, 0, "R8 exponent at width");
        apply(1, 1, 100, ONE, 1, 2, 0, "R8 huge negative");
        apply(2, 0, 0, 64'd0, 0, 0, 0, "R8 +inf");
        apply(2, 1, 0, 64'd0, 0, 0, 0, "R8 -inf");
        // R9: NaNs
        apply(3, 0, 0, ONE, 0, 0, 0, "R9 quiet NaN");
        apply(4, 0, 0, ONE, 1, 2, 0, "R9 signalling NaN");

        // R1: a request while busy is ignored
        begin
            logic [63:0] d; logic [4:0] st;
            model(1, 0, 4, ONE, 0, 0, 0, d, st);
            q_data.push_back(d); q_st.push_back(st); q_tag.push_back("R1 busy ignore");
            @(negedge clk); drive(1, 0, 4, ONE, 0, 0, 0);
            @(negedge clk); drive(1, 1, 9, ONE, 0, 0, 0);
            @(negedge clk); in_valid = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R4 R5 R6 R10: pseudo-random numbers around the range
        for (int k = 0; k < 300; k++) begin
            logic [63:0] m;
            m = {1'b1, 31'($urandom), 32'($urandom)};
            if (k % 7 == 0) m[30:0] = '0;
            apply(1, 1'($urandom), int'($urandom_range(0, 38)) - 4, m,
                  1'($urandom), int'($urandom_range(0, 3)), (k % 11 == 0), "R5/R10 random");
        end

        repeat (4) @(negedge clk);
        checks++;
        if (q_data.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results missing, expected 0", q_data.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule